// File: doc/BRIEF.md
# FIFO Port-Width Matcher with Half Ordering

This block is a single-clock FIFO whose write port and read port are each set to 9 or 18 bits, independently of each other. Storage is kept as two banks of 9-bit halves, so an 18-bit access touches one row of both banks and a 9-bit access touches one bank. Narrow writes are packed into wide words, and wide words are split into narrow reads. The order of the two halves is chosen by an endian setting. Big-endian moves the upper half (bits 17:9) first. Little-endian moves the lower half (bits 8:0) first.

The read port works in show-ahead fashion. The head item is always visible on `rd_data`, and `rd_en` removes it. Occupancy is reported in 9-bit halves. Full and empty are judged against how many halves the next write or read would move. Width and order settings are captured once per reset, at the first rising clock edge after `rst_n` goes high. Writes and reads presented on that same edge are dropped.

Top module: `fifo_width_matcher`

## Requirements
- R1: While reset is active and just after it, `level` is 0, `rd_empty` is 1, `wr_full` is 0 and `rd_data` is 0.
- R2: `cfg_in_wide`, `cfg_out_wide` and `cfg_big_endian` are captured on the first rising edge after `rst_n` deasserts. A write or read presented on that edge is ignored. Later changes to the settings have no effect until the next reset.
- R3: With an 18-bit write port and a 9-bit read port, each stored word yields two reads on `rd_data[8:0]`. Big-endian (`cfg_big_endian`=1) gives bits 17:9 first. Little-endian gives bits 8:0 first.
- R4: With a 9-bit write port and an 18-bit read port, a word becomes readable only after two writes, so a lone half keeps `rd_empty` high. Big-endian places the first write in `rd_data[17:9]`. Little-endian places it in `rd_data[8:0]`.
- R5: When both ports have the same width, data leaves in write order unchanged, whatever the endian setting.
- R6: `level` counts stored 9-bit halves. A wide write adds 2 and a narrow write adds 1. A wide read removes 2 and a narrow read removes 1. A write and a read on the same edge both take effect.
- R7: `wr_full` is high when fewer free halves remain than the write port width in halves. A write while `wr_full` is high is dropped and leaves `level` and the stored data unchanged.
- R8: `rd_empty` is high when fewer halves are stored than the read port width in halves. A read while `rd_empty` is high is dropped.
- R9: Capacity is 2*DEPTH halves, which equals DEPTH wide words, in every organisation.
- R10: `rd_data` is 0 while `rd_empty` is high. With a 9-bit read port, `rd_data[17:9]` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_in_wide | input | 1 | 1: 18-bit write port, 0: 9-bit |
| cfg_out_wide | input | 1 | 1: 18-bit read port, 0: 9-bit |
| cfg_big_endian | input | 1 | 1: upper half moves first, 0: lower half first |
| wr_en | input | 1 | Write request |
| wr_data | input | 18 | Write data; bits 8:0 only in 9-bit mode |
| rd_en | input | 1 | Remove the head item |
| rd_data | output | 18 | Head item, repacked to the read width |
| level | output | 6 | Stored halves (width is clog2(2*DEPTH+1)) |
| wr_full | output | 1 | Next write would not fit |
| rd_empty | output | 1 | No complete read item stored |

## Verification
All four width pairings are exercised, and the two unequal pairings are run under both endian settings. A distinct pattern in each half exposes a swapped or duplicated half. A single narrow write into the 9-to-18 organisation separates committed words from a pending half. A fill to capacity with a wide write port, followed by one narrow read, shows that full is judged in halves rather than words. Changing the settings after the capture edge, and presenting a write on the capture edge, shows that the settings are sampled only once.

// File: rtl/fifo_wm_pkg.sv
package fifo_wm_pkg;

  typedef struct packed {
    logic in_wide;
    logic out_wide;
    logic big_end;
  } wm_mode_t;

endpackage

// File: rtl/wm_cfg_latch.sv
module wm_cfg_latch
  import fifo_wm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  wm_mode_t cfg_in,
  output wm_mode_t mode,
  output logic     active
);

  logic     open_q, open_d;
  wm_mode_t mode_q, mode_d;

  always_comb begin
    open_d = open_q;
    mode_d = mode_q;
    if (open_q) begin
      open_d = 1'b0;
      mode_d = cfg_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b1;
      mode_q <= '0;
    end else begin
      open_q <= open_d;
      mode_q <= mode_d;
    end
  end

  assign mode   = mode_q;
  assign active = !open_q;

  // R2: once captured, the settings stay put
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !open_q |=> $stable(mode_q));

endmodule

// File: rtl/wm_ptr_ctrl.sv
module wm_ptr_ctrl #(
  parameter int HALVES = 32,
  parameter int PTR_W  = 5,
  parameter int LVL_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             in_wide,
  input  logic             out_wide,
  input  logic             wr_en,
  input  logic             rd_en,
  output logic [PTR_W-1:0] wptr,
  output logic [PTR_W-1:0] rptr,
  output logic [LVL_W-1:0] level,
  output logic             wr_full,
  output logic             rd_empty,
  output logic             wr_fire,
  output logic             rd_fire
);

  localparam logic [PTR_W:0] HALVES_P = (PTR_W+1)'(HALVES);
  localparam logic [LVL_W:0] CAP_L    = (LVL_W+1)'(HALVES);

  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [LVL_W:0]   wr_step, rd_step, free_h, lvl_sum;

  function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p,
                                           input logic two);
    logic [PTR_W:0] s;
    s = {1'b0, p} + (two ? (PTR_W+1)'(2) : (PTR_W+1)'(1));
    if (s >= HALVES_P) s = s - HALVES_P;
    return s[PTR_W-1:0];
  endfunction

  always_comb begin
    wr_step  = in_wide  ? (LVL_W+1)'(2) : (LVL_W+1)'(1);
    rd_step  = out_wide ? (LVL_W+1)'(2) : (LVL_W+1)'(1);
    free_h   = CAP_L - {1'b0, lvl_q};
    wr_full  = free_h < wr_step;
    rd_empty = {1'b0, lvl_q} < rd_step;
    wr_fire  = active && wr_en && !wr_full;
    rd_fire  = active && rd_en && !rd_empty;
  end

  always_comb begin
    wptr_d  = wr_fire ? adv(wptr_q, in_wide)  : wptr_q;
    rptr_d  = rd_fire ? adv(rptr_q, out_wide) : rptr_q;
    lvl_sum = {1'b0, lvl_q};
    if (wr_fire) lvl_sum = lvl_sum + wr_step;
    if (rd_fire) lvl_sum = lvl_sum - rd_step;
    lvl_d   = lvl_sum[LVL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      lvl_q  <= lvl_d;
    end
  end

  assign wptr  = wptr_q;
  assign rptr  = rptr_q;
  assign level = lvl_q;

  p_level_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, lvl_q} <= CAP_L);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_full && !rd_fire) |=> (lvl_q <= $past(lvl_q)));

  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_empty && !wr_fire) |=> (lvl_q >= $past(lvl_q)));

  // R4: a wide read port only ever starts on an even half
  p_rd_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && out_wide) |-> !rptr_q[0]);

endmodule

// File: rtl/wm_half_store.sv
module wm_half_store #(
  parameter int HALF_W = 9,
  parameter int ROWS   = 16,
  parameter int ROW_W  = 4
) (
  input  logic                        clk,
  input  logic [1:0]                  we,
  input  logic [ROW_W-1:0]            wrow,
  input  logic [1:0][HALF_W-1:0]      wdata,
  input  logic [ROW_W-1:0]            rrow,
  output logic [1:0][HALF_W-1:0]      rdata
);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [HALF_W-1:0] mem [ROWS];

    always_ff @(posedge clk) begin
      if (we[b]) mem[wrow] <= wdata[b];
    end

    assign rdata[b] = mem[rrow];
  end

endmodule

// File: rtl/wm_lane_steer.sv
module wm_lane_steer
  import fifo_wm_pkg::*;
#(
  parameter int HALF_W = 9
) (
  input  wm_mode_t                mode,
  input  logic                    wr_fire,
  input  logic [2*HALF_W-1:0]     wr_data,
  input  logic                    wptr_lsb,
  input  logic                    rptr_lsb,
  input  logic                    rd_empty,
  input  logic [1:0][HALF_W-1:0]  bank_q,
  output logic [1:0]              we,
  output logic [1:0][HALF_W-1:0]  bank_d,
  output logic [2*HALF_W-1:0]     rd_data
);

  logic [HALF_W-1:0] w_hi, w_lo;

  assign w_hi = wr_data[2*HALF_W-1:HALF_W];
  assign w_lo = wr_data[HALF_W-1:0];

  // bank 0 always holds the half that moves first
  always_comb begin
    we     = 2'b00;
    bank_d = '0;
    if (mode.in_wide) begin
      bank_d[0] = mode.big_end ? w_hi : w_lo;
      bank_d[1] = mode.big_end ? w_lo : w_hi;
      if (wr_fire) we = 2'b11;
    end else begin
      bank_d[0] = w_lo;
      bank_d[1] = w_lo;
      if (wr_fire) we = wptr_lsb ? 2'b10 : 2'b01;
    end
  end

  always_comb begin
    rd_data = '0;
    if (!rd_empty) begin
      if (mode.out_wide)
        rd_data = mode.big_end ? {bank_q[0], bank_q[1]} : {bank_q[1], bank_q[0]};
      else
        rd_data = {{HALF_W{1'b0}}, (rptr_lsb ? bank_q[1] : bank_q[0])};
    end
  end

endmodule

// File: rtl/fifo_width_matcher.sv
module fifo_width_matcher
  import fifo_wm_pkg::*;
#(
  parameter  int HALF_W = 9,
  parameter  int DEPTH  = 16,
  localparam int WORD_W = 2 * HALF_W,
  localparam int HALVES = 2 * DEPTH,
  localparam int PTR_W  = $clog2(HALVES),
  localparam int LVL_W  = $clog2(HALVES + 1),
  localparam int ROW_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_in_wide,
  input  logic              cfg_out_wide,
  input  logic              cfg_big_endian,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic [LVL_W-1:0]  level,
  output logic              wr_full,
  output logic              rd_empty
);

  wm_mode_t                 cfg_in, mode;
  logic                     active, wr_fire, rd_fire;
  logic [PTR_W-1:0]         wptr, rptr;
  logic [1:0]               we;
  logic [1:0][HALF_W-1:0]   bank_d, bank_q;
  logic [ROW_W-1:0]         wrow, rrow;

  assign cfg_in = '{in_wide: cfg_in_wide, out_wide: cfg_out_wide,
                    big_end: cfg_big_endian};

  wm_cfg_latch u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_in (cfg_in),
    .mode   (mode),
    .active (active)
  );

  wm_ptr_ctrl #(.HALVES(HALVES), .PTR_W(PTR_W), .LVL_W(LVL_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .in_wide  (mode.in_wide),
    .out_wide (mode.out_wide),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wptr     (wptr),
    .rptr     (rptr),
    .level    (level),
    .wr_full  (wr_full),
    .rd_empty (rd_empty),
    .wr_fire  (wr_fire),
    .rd_fire  (rd_fire)
  );

  assign wrow = ROW_W'(wptr >> 1);
  assign rrow = ROW_W'(rptr >> 1);

  wm_half_store #(.HALF_W(HALF_W), .ROWS(DEPTH), .ROW_W(ROW_W)) u_store (
    .clk   (clk),
    .we    (we),
    .wrow  (wrow),
    .wdata (bank_d),
    .rrow  (rrow),
    .rdata (bank_q)
  );

  wm_lane_steer #(.HALF_W(HALF_W)) u_steer (
    .mode     (mode),
    .wr_fire  (wr_fire),
    .wr_data  (wr_data),
    .wptr_lsb (wptr[0]),
    .rptr_lsb (rptr[0]),
    .rd_empty (rd_empty),
    .bank_q   (bank_q),
    .we       (we),
    .bank_d   (bank_d),
    .rd_data  (rd_data)
  );

  p_empty_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_empty |-> (rd_data == '0));

  p_narrow_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mode.out_wide |-> (rd_data[WORD_W-1:HALF_W] == '0));

  // R1: nothing is stored or fired before the settings are captured
  p_idle_before_cfg_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (level == '0 && !wr_fire && !rd_fire));

endmodule

// File: tb/fifo_width_matcher_tb_top.sv
`timescale 1ns/1ps
module fifo_width_matcher_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_in_wide, cfg_out_wide, cfg_big_endian;
  logic        wr_en, rd_en;
  logic [17:0] wr_data;
  logic [17:0] rd_data;
  logic [5:0]  level;
  logic        wr_full, rd_empty;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  fifo_width_matcher dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_in_wide    (cfg_in_wide),
    .cfg_out_wide   (cfg_out_wide),
    .cfg_big_endian (cfg_big_endian),
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .rd_en          (rd_en),
    .rd_data        (rd_data),
    .level          (level),
    .wr_full        (wr_full),
    .rd_empty       (rd_empty)
  );

  typedef struct packed {
    logic        wr;
    logic [17:0] wd;
    logic        rd;
    logic [17:0] ed;
    logic [5:0]  el;
    logic        ee;
  } vec_t;

  // 18-bit write, 9-bit read, big-endian; expected state after each action
  localparam vec_t VEC [6] = '{
    '{1'b1, 18'h34AC3, 1'b0, 18'h001A5, 6'd2, 1'b0},  // R3 upper first
    '{1'b1, 18'h0FD00, 1'b1, 18'h000C3, 6'd3, 1'b0},  // R6 write+read together
    '{1'b0, 18'h00000, 1'b1, 18'h0007E, 6'd2, 1'b0},  // R3
    '{1'b0, 18'h00000, 1'b1, 18'h00100, 6'd1, 1'b0},  // R3
    '{1'b0, 18'h00000, 1'b1, 18'h00000, 6'd0, 1'b1},  // R10 zero when empty
    '{1'b0, 18'h00000, 1'b1, 18'h00000, 6'd0, 1'b1}   // R8 read while empty
  };

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // drive at a falling edge, commit on the rising edge, return at the next falling edge
  task automatic cyc(input logic w, input logic [17:0] d, input logic r);
    wr_en = w; wr_data = d; rd_en = r;
    @(posedge clk); #1;
    wr_en = 1'b0; rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset(input logic iw, input logic ow, input logic be);
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    cfg_in_wide = iw; cfg_out_wide = ow; cfg_big_endian = be;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 and R2: reset state, then a write on the capture edge is dropped
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    cfg_in_wide = 1'b1; cfg_out_wide = 1'b0; cfg_big_endian = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 level", 32'(level), 0);
    check("R1 rd_empty", 32'(rd_empty), 1);
    check("R1 wr_full", 32'(wr_full), 0);
    check("R1 rd_data", 32'(rd_data), 0);
    rst_n = 1'b1; wr_en = 1'b1; wr_data = 18'h3FFFF;
    @(posedge clk); #1; wr_en = 1'b0;
    @(negedge clk);
    check("R2 write on capture edge ignored", 32'(level), 0);

    for (int i = 0; i < 6; i++) begin
      cyc(VEC[i].wr, VEC[i].wd, VEC[i].rd);
      check("R3/R6 table data", 32'(rd_data), 32'(VEC[i].ed));
      check("R6 table level", 32'(level), 32'(VEC[i].el));
      check("R8 table empty", 32'(rd_empty), 32'(VEC[i].ee));
    end

    // R4 big-endian, 9-bit write, 18-bit read
    do_reset(1'b0, 1'b1, 1'b1);
    cyc(1'b1, 18'h00055, 1'b0);
    check("R4 lone half level", 32'(level), 1);
    check("R4 lone half hidden", 32'(rd_empty), 1);
    check("R10 data zero while empty", 32'(rd_data), 0);
    cyc(1'b1, 18'h001F0, 1'b0);
    check("R4 BE packed word", 32'(rd_data), 32'h0ABF0);
    cfg_out_wide = 1'b0; cfg_big_endian = 1'b0; cfg_in_wide = 1'b1;
    cyc(1'b0, 18'h0, 1'b0);
    check("R2 late settings ignored", 32'(rd_data), 32'h0ABF0);
    cyc(1'b0, 18'h0, 1'b1);
    check("R6 wide read removes 2", 32'(level), 0);

    // R4 little-endian
    do_reset(1'b0, 1'b1, 1'b0);
    cyc(1'b1, 18'h00055, 1'b0);
    cyc(1'b1, 18'h001F0, 1'b0);
    check("R4 LE packed word", 32'(rd_data), 32'h3E055);

    // R3 little-endian
    do_reset(1'b1, 1'b0, 1'b0);
    cyc(1'b1, 18'h34AC3, 1'b0);
    check("R3 LE lower first", 32'(rd_data), 32'h000C3);
    cyc(1'b0, 18'h0, 1'b1);
    check("R3 LE upper second", 32'(rd_data), 32'h001A5);

    // R5 equal widths
    do_reset(1'b1, 1'b1, 1'b0);
    cyc(1'b1, 18'h34AC3, 1'b0);
    check("R5 wide passthrough", 32'(rd_data), 32'h34AC3);
    do_reset(1'b0, 1'b0, 1'b1);
    cyc(1'b1, 18'h00011, 1'b0);
    cyc(1'b1, 18'h00022, 1'b0);
    cyc(1'b1, 18'h00033, 1'b0);
    check("R6 narrow writes add 1", 32'(level), 3);
    check("R5 narrow order 1", 32'(rd_data), 32'h011);
    cyc(1'b0, 18'h0, 1'b1);
    check("R5 narrow order 2", 32'(rd_data), 32'h022);
    cyc(1'b0, 18'h0, 1'b1);
    check("R5 narrow order 3", 32'(rd_data), 32'h033);

    // R7 and R9: fill with wide writes, narrow reads
    do_reset(1'b1, 1'b0, 1'b1);
    for (int k = 0; k < 16; k++)
      cyc(1'b1, {9'(k + 1), 9'(k + 'h40)}, 1'b0);
    check("R9 capacity level", 32'(level), 32);
    check("R9 full at capacity", 32'(wr_full), 1);
    cyc(1'b1, 18'h3FFFF, 1'b0);
    check("R7 write while full dropped", 32'(level), 32);
    for (int k = 0; k < 16; k++) begin
      check("R3 fill upper", 32'(rd_data), 32'(k + 1));
      cyc(1'b0, 18'h0, 1'b1);
      if (k == 0) begin
        check("R7 one free half still full", 32'(wr_full), 1);
        check("R6 narrow read removes 1", 32'(level), 31);
      end
      check("R3 fill lower", 32'(rd_data), 32'(k + 'h40));
      cyc(1'b0, 18'h0, 1'b1);
      if (k == 0) check("R7 two free halves not full", 32'(wr_full), 0);
    end
    check("R8 drained", 32'(rd_empty), 1);

    // R9: narrow write port also holds 2*DEPTH halves
    do_reset(1'b0, 1'b1, 1'b1);
    for (int k = 0; k < 31; k++) cyc(1'b1, 18'(k), 1'b0);
    check("R7 one free half accepts narrow", 32'(wr_full), 0);
    cyc(1'b1, 18'h0001F, 1'b0);
    check("R9 narrow capacity", 32'(level), 32);
    check("R9 narrow full", 32'(wr_full), 1);

    finish_run();
  end

endmodule